// File: doc/BRIEF.md
# Configuration Status Interrupt Monitor

This block watches twelve status lines that come from a configurable fabric's configuration logic. It turns them into one interrupt request. Each line passes through a two-stage synchroniser. Each line then has its own controls:

- an enable bit;
- a mask bit;
- a level/edge type bit;
- a polarity bit.

A small register window, addressed by byte offset, exposes these controls. The window also holds:

- the raw status vector;
- the masked status vector;
- a write-only end-of-interrupt register that clears latched edge events;
- a read-only port that returns the synchronised live inputs.

Software typically enables only the line it waits for. It chooses active-high or active-low for that line. It waits for the interrupt, then acknowledges the event through the end-of-interrupt register. Every register uses the same bit-to-line mapping:

| Bit | Line |
|-----|------|
| 0 | status (active-low error) |
| 1 | configuration done |
| 2 | initialisation done |
| 3 | CRC error |
| 4 | configuration-via-link done |
| 5 | partial-reconfiguration ready |
| 6 | partial-reconfiguration error |
| 7 | partial-reconfiguration done |
| 8 | config-request pin |
| 9 | status pin |
| 10 | configuration-done pin |
| 11 | fabric power good |

Top module: `statusIrqTop`

## Requirements
- R1: After reset, the enable, mask, type and polarity registers read 0, the masked status reads 0 and the interrupt output is low.
- R2: The port register at offset 0x850 returns the input vector with bit i equal to input line i. A change on an input appears there after exactly two rising clock edges.
- R3: A line whose type bit is 0 is level sensitive. Its raw status bit, at offset 0x844, is 1 while the synchronised input equals its polarity bit: polarity 1 means active high and polarity 0 means active low. A write to end-of-interrupt does not change it.
- R4: A line whose type bit is 1 is edge sensitive. Its raw status bit latches on the active edge: rising edge when polarity is 1, falling edge when polarity is 0. The bit stays set after the input returns. Only a 1 written to that bit of end-of-interrupt (offset 0x84C) clears it. Bits written as 0 are left unchanged.
- R5: Masked status, at offset 0x840, equals raw AND enable AND NOT mask. The interrupt output is high exactly when any masked status bit is 1. A mask bit of 0 lets an enabled line through.
- R6: An enable bit of 0 blocks the line from the interrupt. It also clears any latched edge event and prevents new ones from latching. Writing 0 to the enable register (offset 0x830) therefore silences every source.
- R7: If an active edge is detected on a line in the same cycle as an end-of-interrupt write that clears that line, the new event stays latched.
- R8: The control registers sit at these offsets, read back what was written, and reset to 0:

  | Offset | Register |
  |--------|----------|
  | 0x830 | enable |
  | 0x834 | mask |
  | 0x838 | type |
  | 0x83C | polarity |

  Writes to 0x840, 0x844 and 0x850 are ignored. End-of-interrupt reads as 0, and any unmapped offset reads as 0.
- R9: Changing a polarity bit while the input is steady creates no edge event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| monIn | input | NUM_IN (12) | Asynchronous status lines, bit mapping as above |
| busAddr | input | 12 | Byte offset of the register access |
| busWrEn | input | 1 | Write strobe, sampled on the rising edge |
| busWrData | input | NUM_IN (12) | Write data |
| busRdData | output | NUM_IN (12) | Read data for busAddr, combinational |
| irqOut | output | 1 | Interrupt request, active high |

## Verification
Two functions can fall in the same clock edge: an acknowledge write to end-of-interrupt, and the capture of a fresh active edge on the line being acknowledged.

The bench first latches one edge line. It then raises a second edge line and counts the synchroniser and edge-detector stages. From that count it places the acknowledge write, covering both lines, on exactly the edge at which the second event latches.

The outcome is judged at the raw status register. The earlier event must be gone and the new one must survive. A check one cycle earlier confirms that the new event had not yet latched before that edge.

// File: rtl/statusIrqPkg.sv
package statusIrqPkg;

  localparam int unsigned ADDR_W = 12;

  // byte offsets of the register window
  localparam logic [ADDR_W-1:0] OFS_ENABLE = 12'h830;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h834;
  localparam logic [ADDR_W-1:0] OFS_TYPE   = 12'h838;
  localparam logic [ADDR_W-1:0] OFS_POL    = 12'h83C;
  localparam logic [ADDR_W-1:0] OFS_MSKST  = 12'h840;
  localparam logic [ADDR_W-1:0] OFS_RAWST  = 12'h844;
  localparam logic [ADDR_W-1:0] OFS_EOI    = 12'h84C;
  localparam logic [ADDR_W-1:0] OFS_PORT   = 12'h850;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_ENABLE,
    RD_MASK,
    RD_TYPE,
    RD_POL,
    RD_MASKED,
    RD_RAW,
    RD_PORT
  } rdSel_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic   wrEnable;
    logic   wrMask;
    logic   wrType;
    logic   wrPol;
    logic   wrEoi;
    rdSel_e rdSel;
  } ctlStrobe_t;

endpackage

// File: rtl/statusIrqSync.sv
module statusIrqSync #(
  parameter int unsigned WIDTH  = 12,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= din;
      end
    end else begin : gNext
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[g] <= '0;
        else       stage[g] <= stage[g-1];
      end
    end
  end

  assign dout = stage[STAGES-1];

endmodule

// File: rtl/statusIrqDecode.sv
module statusIrqDecode
  import statusIrqPkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output ctlStrobe_t        ctl
);

  always_comb begin
    ctl       = '0;
    ctl.rdSel = RD_NONE;
    case (busAddr)
      OFS_ENABLE: begin ctl.wrEnable = busWrEn; ctl.rdSel = RD_ENABLE; end
      OFS_MASK:   begin ctl.wrMask   = busWrEn; ctl.rdSel = RD_MASK;   end
      OFS_TYPE:   begin ctl.wrType   = busWrEn; ctl.rdSel = RD_TYPE;   end
      OFS_POL:    begin ctl.wrPol    = busWrEn; ctl.rdSel = RD_POL;    end
      OFS_MSKST:  ctl.rdSel = RD_MASKED;
      OFS_RAWST:  ctl.rdSel = RD_RAW;
      OFS_EOI:    ctl.wrEoi = busWrEn;
      OFS_PORT:   ctl.rdSel = RD_PORT;
      default:    ;
    endcase
  end

endmodule

// File: rtl/statusIrqDatapath.sv
module statusIrqDatapath
  import statusIrqPkg::*;
#(
  parameter int unsigned NUM_IN      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] monIn,
  input  ctlStrobe_t        ctl,
  input  logic [NUM_IN-1:0] wrData,
  output logic [NUM_IN-1:0] rdData,
  output logic              irqOut,
  output logic [NUM_IN-1:0] syncVal,
  output logic [NUM_IN-1:0] edgeEvt,
  output logic [NUM_IN-1:0] edgeLatch,
  output logic [NUM_IN-1:0] enReg,
  output logic [NUM_IN-1:0] typeReg
);

  logic [NUM_IN-1:0] maskReg;
  logic [NUM_IN-1:0] polReg;
  logic [NUM_IN-1:0] prevVal;
  logic [NUM_IN-1:0] eoiBits;
  logic [NUM_IN-1:0] latchNext;
  logic [NUM_IN-1:0] levelAct;
  logic [NUM_IN-1:0] rawStat;
  logic [NUM_IN-1:0] maskedStat;

  statusIrqSync #(
    .WIDTH (NUM_IN),
    .STAGES(SYNC_STAGES)
  ) uSync (
    .clk (clk),
    .rstN(rstN),
    .din (monIn),
    .dout(syncVal)
  );

  // control registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enReg   <= '0;
      maskReg <= '0;
      typeReg <= '0;
      polReg  <= '0;
    end else begin
      if (ctl.wrEnable) enReg   <= wrData;
      if (ctl.wrMask)   maskReg <= wrData;
      if (ctl.wrType)   typeReg <= wrData;
      if (ctl.wrPol)    polReg  <= wrData;
    end
  end

  // edge detection on the synchronised vector
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevVal <= '0;
    else       prevVal <= syncVal;
  end

  assign edgeEvt = (syncVal & ~prevVal & polReg) | (~syncVal & prevVal & ~polReg);
  assign eoiBits = ctl.wrEoi ? wrData : '0;

  // a new event outranks a clear in the same cycle
  assign latchNext = enReg & typeReg & ((edgeLatch & ~eoiBits) | edgeEvt);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) edgeLatch <= '0;
    else       edgeLatch <= latchNext;
  end

  // status vectors
  assign levelAct   = ~(syncVal ^ polReg);
  assign rawStat    = (typeReg & edgeLatch) | (~typeReg & levelAct);
  assign maskedStat = rawStat & enReg & ~maskReg;
  assign irqOut     = |maskedStat;

  // read mux
  always_comb begin
    case (ctl.rdSel)
      RD_ENABLE: rdData = enReg;
      RD_MASK:   rdData = maskReg;
      RD_TYPE:   rdData = typeReg;
      RD_POL:    rdData = polReg;
      RD_MASKED: rdData = maskedStat;
      RD_RAW:    rdData = rawStat;
      RD_PORT:   rdData = syncVal;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/statusIrqTop.sv
module statusIrqTop
  import statusIrqPkg::*;
#(
  parameter int unsigned NUM_IN      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IN-1:0] monIn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [NUM_IN-1:0] busWrData,
  output logic [NUM_IN-1:0] busRdData,
  output logic              irqOut
);

  ctlStrobe_t        ctl;
  logic [NUM_IN-1:0] syncVal;
  logic [NUM_IN-1:0] edgeEvt;
  logic [NUM_IN-1:0] edgeLatch;
  logic [NUM_IN-1:0] enReg;
  logic [NUM_IN-1:0] typeReg;

  statusIrqDecode uDecode (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .ctl    (ctl)
  );

  statusIrqDatapath #(
    .NUM_IN     (NUM_IN),
    .SYNC_STAGES(SYNC_STAGES)
  ) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .monIn    (monIn),
    .ctl      (ctl),
    .wrData   (busWrData),
    .rdData   (busRdData),
    .irqOut   (irqOut),
    .syncVal  (syncVal),
    .edgeEvt  (edgeEvt),
    .edgeLatch(edgeLatch),
    .enReg    (enReg),
    .typeReg  (typeReg)
  );

endmodule

// File: rtl/statusIrqChecker.sv
module statusIrqChecker
  import statusIrqPkg::*;
#(
  parameter int unsigned NUM_IN = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_IN-1:0] monIn,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [NUM_IN-1:0] busWrData,
  input logic              irqOut,
  input logic [NUM_IN-1:0] syncVal,
  input logic [NUM_IN-1:0] edgeEvt,
  input logic [NUM_IN-1:0] edgeLatch,
  input logic [NUM_IN-1:0] enReg,
  input logic [NUM_IN-1:0] typeReg
);

  logic [1:0]        warmCnt;
  logic              eoiHit;
  logic [NUM_IN-1:0] eoiVec;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  assign eoiHit = busWrEn && (busAddr == OFS_EOI);
  assign eoiVec = eoiHit ? busWrData : '0;

  AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rstN)
    (warmCnt >= 2'd2) |-> (syncVal == $past(monIn, 2)));  // R2

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(edgeLatch & enReg & typeReg & ~eoiVec) & ~edgeLatch) == '0));  // R4

  AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (($past(edgeEvt & enReg & typeReg) & ~edgeLatch) == '0));  // R7

  AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((edgeLatch & ~$past(enReg)) == '0));  // R6

  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (enReg == '0) |-> !irqOut);  // R6

endmodule

bind statusIrqTop statusIrqChecker #(.NUM_IN(NUM_IN)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .monIn    (monIn),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .irqOut   (irqOut),
  .syncVal  (syncVal),
  .edgeEvt  (edgeEvt),
  .edgeLatch(edgeLatch),
  .enReg    (enReg),
  .typeReg  (typeReg)
);

// File: tb/tb_statusIrqTop.sv
module tb_statusIrqTop;

  localparam int unsigned NW = 12;

  localparam logic [11:0] A_EN   = 12'h830;
  localparam logic [11:0] A_MSK  = 12'h834;
  localparam logic [11:0] A_TYP  = 12'h838;
  localparam logic [11:0] A_POL  = 12'h83C;
  localparam logic [11:0] A_MST  = 12'h840;
  localparam logic [11:0] A_RAW  = 12'h844;
  localparam logic [11:0] A_EOI  = 12'h84C;
  localparam logic [11:0] A_PORT = 12'h850;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NW-1:0] monIn = '0;
  logic [11:0]   busAddr = '0;
  logic          busWrEn = 1'b0;
  logic [NW-1:0] busWrData = '0;
  logic [NW-1:0] busRdData;
  logic          irqOut;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  statusIrqTop dut (
    .clk      (clk),
    .rstN     (rstN),
    .monIn    (monIn),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .irqOut   (irqOut)
  );

  task automatic chk(input string req, input logic [NW-1:0] act, input logic [NW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%03h expected=%03h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [NW-1:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [NW-1:0] d);
    @(negedge clk);
    busAddr = a;
    #1 d = busRdData;
  endtask

  task automatic setIn(input logic [NW-1:0] v);
    @(negedge clk);
    monIn = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset();
    logic [NW-1:0] v;
    rd(A_EN, v);  chk("R1 enable", v, '0);
    rd(A_MSK, v); chk("R1 mask", v, '0);
    rd(A_TYP, v); chk("R1 type", v, '0);
    rd(A_POL, v); chk("R1 polarity", v, '0);
    rd(A_MST, v); chk("R1 masked", v, '0);
    chk("R1 irq", {11'd0, irqOut}, '0);
    rd(A_RAW, v); chk("R3 active-low level after reset", v, 12'hFFF);
  endtask

  task automatic testSync();
    logic [NW-1:0] v;
    @(negedge clk);
    busAddr = A_PORT;
    monIn = 12'hA5C;
    @(negedge clk); #1 v = busRdData; chk("R2 port after one edge", v, 12'h000);
    @(negedge clk); #1 v = busRdData; chk("R2 port after two edges", v, 12'hA5C);
    setIn(12'h002);
    rd(A_PORT, v); chk("R2 bit1 mapping", v, 12'h002);
    setIn(12'h000);
  endtask

  task automatic testLevel();
    logic [NW-1:0] v;
    wr(A_POL, 12'hFFF);
    setIn(12'h00F);
    rd(A_RAW, v); chk("R3 active-high level", v, 12'h00F);
    wr(A_POL, 12'h0F0);
    rd(A_RAW, v); chk("R3 mixed polarity", v, 12'hF00);
    wr(A_EOI, 12'hFFF);
    rd(A_RAW, v); chk("R3 eoi ignored on level", v, 12'hF00);
  endtask

  task automatic testMask();
    logic [NW-1:0] v;
    wr(A_EN, 12'hFFF);
    wr(A_MSK, 12'hFF0);
    rd(A_MST, v); chk("R5 all masked", v, 12'h000);
    chk("R5 irq low when masked", {11'd0, irqOut}, '0);
    wr(A_MSK, 12'h0FF);
    rd(A_MST, v); chk("R5 unmasked", v, 12'hF00);
    chk("R5 irq high", {11'd0, irqOut}, 12'h001);
    wr(A_EN, 12'h100);
    rd(A_MST, v); chk("R5 partial enable", v, 12'h100);
    wr(A_EN, 12'h000);
    rd(A_MST, v); chk("R6 enable zero masked", v, 12'h000);
    chk("R6 irq low", {11'd0, irqOut}, '0);
    wr(A_MSK, 12'h000);
  endtask

  task automatic testEdge();
    logic [NW-1:0] v;
    setIn(12'h000);
    wr(A_POL, 12'h003);
    wr(A_TYP, 12'hFFF);
    wr(A_EN, 12'hFFF);
    rd(A_RAW, v); chk("R4 idle edge", v, 12'h000);
    setIn(12'h003);
    rd(A_RAW, v); chk("R4 rising latch", v, 12'h003);
    chk("R5 irq on edge", {11'd0, irqOut}, 12'h001);
    setIn(12'h000);
    rd(A_RAW, v); chk("R4 hold after return", v, 12'h003);
    wr(A_EOI, 12'h001);
    rd(A_RAW, v); chk("R4 selective clear", v, 12'h002);
    wr(A_EOI, 12'h002);
    rd(A_RAW, v); chk("R4 full clear", v, 12'h000);
    chk("R4 irq cleared", {11'd0, irqOut}, '0);
    setIn(12'h004);
    rd(A_RAW, v); chk("R4 rising ignored when active-low", v, 12'h000);
    setIn(12'h000);
    rd(A_RAW, v); chk("R4 falling latch", v, 12'h004);
  endtask

  task automatic testPolarityChange();
    logic [NW-1:0] v;
    wr(A_EOI, 12'hFFF);
    wr(A_POL, 12'h023);
    repeat (3) @(negedge clk);
    rd(A_RAW, v); chk("R9 polarity change no event", v, 12'h000);
  endtask

  task automatic testDisable();
    logic [NW-1:0] v;
    setIn(12'h008);
    setIn(12'h000);
    rd(A_RAW, v); chk("R4 bit3 falling latched", v, 12'h008);
    wr(A_EN, 12'h000);
    rd(A_RAW, v); chk("R6 latch cleared by disable", v, 12'h000);
    setIn(12'h008);
    setIn(12'h000);
    wr(A_EN, 12'hFFF);
    rd(A_RAW, v); chk("R6 no latch while disabled", v, 12'h000);
    chk("R6 irq low after reenable", {11'd0, irqOut}, '0);
  endtask

  task automatic testCollision();
    logic [NW-1:0] v;
    setIn(12'h001);
    rd(A_RAW, v); chk("R7 first event latched", v, 12'h001);
    @(negedge clk);
    monIn = 12'h003;
    busAddr = A_RAW;
    @(negedge clk);
    @(negedge clk);
    #1 v = busRdData; chk("R7 second event not yet latched", v, 12'h001);
    busAddr = A_EOI; busWrData = 12'h003; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    rd(A_RAW, v); chk("R7 new edge survives eoi", v, 12'h002);
    wr(A_EOI, 12'hFFF);
    setIn(12'h000);
  endtask

  task automatic testMap();
    logic [NW-1:0] v;
    wr(A_MSK, 12'hABC);
    rd(A_MSK, v); chk("R8 mask readback", v, 12'hABC);
    wr(A_MSK, 12'h000);
    wr(A_TYP, 12'h000);
    wr(A_POL, 12'h000);
    rd(A_RAW, v); chk("R8 raw before write", v, 12'hFFF);
    wr(A_RAW, 12'h000);
    wr(A_MST, 12'h000);
    wr(A_PORT, 12'hFFF);
    rd(A_RAW, v); chk("R8 raw write ignored", v, 12'hFFF);
    rd(A_PORT, v); chk("R8 port write ignored", v, 12'h000);
    rd(A_EOI, v); chk("R8 eoi reads zero", v, 12'h000);
    rd(12'h848, v); chk("R8 unmapped reads zero", v, 12'h000);
    rd(A_EN, v); chk("R8 enable readback", v, 12'hFFF);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : mainSeq
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    testSync();
    testLevel();
    testMask();
    testEdge();
    testPolarityChange();
    testDisable();
    testCollision();
    testMap();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule